// File: doc/BRIEF.md
# UART FIFO Data Path with Receive Trigger and Flow Control

This block holds the byte queues between a UART serial core and the host register interface. Received bytes from the core go into a 32-entry receive queue, which the host drains with a pop strobe. Bytes the host writes go into a 32-entry transmit queue, which is handed to the core one byte at a time whenever the core is idle. Both fill levels, the empty and full flags and a sticky overrun flag are visible to the host. A separate clear strobe for each queue empties it in one cycle.

A two-bit trigger field selects the receive fill level at which the data-available interrupt rises. The choices are 1 byte or 1/2, 3/4 or 7/8 of the depth, which gives 1, 16, 24 and 28 bytes at the default depth. When automatic flow control is enabled, the same threshold drops the request-to-send output, so the far end pauses. The clear-to-send input then gates the start of each new transmit byte. A byte the core is already shifting is not affected, because the block only decides when the next byte starts.

Top module: `uart_fifo_path`

## Requirements
- R1: Each queue holds up to DEPTH (default 32) bytes. After reset both levels read 0, `rx_empty` is 1, and `tx_full`, `rx_irq` and `overrun` are 0. A level never exceeds DEPTH.
- R2: `trig_sel` encodes the receive trigger as 2'b00 = 1, 2'b01 = DEPTH/2, 2'b10 = 3*DEPTH/4 and 2'b11 = 7*DEPTH/8 bytes. `rx_irq` is 1 whenever `rx_level` is at or above the selected trigger.
- R3: `rx_irq` is 0 whenever `rx_level` is below the selected trigger, including right after host pops or a change of `trig_sel` bring it below.
- R4: With `afc_en` = 1, `rts` is 0 while `rx_level` is at or above the trigger and 1 otherwise. With `afc_en` = 0, `rts` is always 1.
- R5: With `afc_en` = 1 and `cts` = 0, `core_tx_start` stays 0. With `afc_en` = 0, `cts` has no effect.
- R6: A `tx_push` while the transmit queue holds DEPTH bytes and no byte leaves in that cycle is dropped. The level stays at DEPTH and the queued bytes are unchanged.
- R7: A `core_rx_valid` byte that arrives while the receive queue is full and not popped is dropped and sets `overrun`. `overrun` stays 1 until a cycle with `ovr_clr` = 1.
- R8: A pulse on `rx_fifo_clr` (or `tx_fifo_clr`) leaves that queue empty after the next clock edge and does not change the other queue. A clear wins over a push or pop in the same cycle.
- R9: Both queues are first-in first-out. `rx_rdata` shows the oldest received byte, and `core_tx_data` shows the oldest host byte.
- R10: `core_tx_start` is 1 exactly when the transmit queue is non-empty, `core_tx_ready` is 1 and the flow-control gate is open. Each cycle with `core_tx_start` = 1 removes one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_sel | input | 2 | Receive trigger select |
| afc_en | input | 1 | Automatic flow control enable |
| rx_fifo_clr | input | 1 | Empty the receive queue |
| tx_fifo_clr | input | 1 | Empty the transmit queue |
| ovr_clr | input | 1 | Clear the overrun flag |
| tx_push | input | 1 | Host write strobe |
| tx_wdata | input | DATA_W | Host write byte |
| rx_pop | input | 1 | Host read strobe |
| rx_rdata | output | DATA_W | Oldest received byte |
| rx_level | output | LVL_W | Receive fill level |
| tx_level | output | LVL_W | Transmit fill level |
| rx_empty | output | 1 | Receive queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_irq | output | 1 | Receive data-available interrupt |
| overrun | output | 1 | Sticky receive overrun flag |
| core_rx_valid | input | 1 | Core delivers a received byte |
| core_rx_data | input | DATA_W | Received byte from core |
| core_tx_ready | input | 1 | Core can accept a byte |
| core_tx_start | output | 1 | Hand a byte to the core this cycle |
| core_tx_data | output | DATA_W | Byte handed to the core |
| cts | input | 1 | Clear to send, 1 = asserted |
| rts | output | 1 | Request to send, 1 = asserted |

## Verification
Levels, `rx_rdata`, `overrun` and the queue contents change at the first clock edge after a strobe. The bench therefore drives every strobe on a falling edge and checks the result at the next falling edge. `rx_irq`, `rts` and `core_tx_start` are combinational from the registered levels and from `trig_sel`, `afc_en`, `cts` and `core_tx_ready`, so a change to one of those inputs is checked one time unit later in the same cycle. A monitor samples each transmit handoff just after the falling edge and compares it against the queue of bytes the driver pushed.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'b00,
        TRIG_HALF    = 2'b01,
        TRIG_3QUART  = 2'b10,
        TRIG_7EIGHTH = 2'b11
    } rx_trig_e;

    // Fill level at which the receive interrupt rises, scaled from depth.
    function automatic int unsigned trig_bytes(rx_trig_e sel, int unsigned depth);
        case (sel)
            TRIG_ONE:    return 1;
            TRIG_HALF:   return depth / 2;
            TRIG_3QUART: return (depth * 3) / 4;
            default:     return (depth * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/ufp_queue.sv
module ufp_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              drop_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] cnt;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.cnt != '0) && !clr_i;
        do_push = push_i && !clr_i && ((st_q.cnt != LVL_W'(DEPTH)) || do_pop);
        drop_o  = push_i && !clr_i && !do_push;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = bump(st_q.wr);
            if (do_pop)  st_d.rd = bump(st_q.rd);
            st_d.cnt = st_q.cnt + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= din_i;
    end

    assign dout_o  = mem_q[st_q.rd];
    assign level_o = st_q.cnt;
    assign full_o  = (st_q.cnt == LVL_W'(DEPTH));
    assign empty_o = (st_q.cnt == '0);

endmodule

// File: rtl/ufp_rx_watch.sv
module ufp_rx_watch
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH  = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             afc_en_i,
    output logic             irq_o,
    output logic             rts_o
);

    logic [LVL_W-1:0] thresh;
    logic             at_trig;

    always_comb begin
        thresh  = LVL_W'(trig_bytes(rx_trig_e'(trig_sel_i), DEPTH));
        at_trig = (level_i >= thresh);
        irq_o   = at_trig;
        rts_o   = !(afc_en_i && at_trig);
    end

endmodule

// File: rtl/uart_fifo_path.sv
module uart_fifo_path #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        trig_sel,
    input  logic              afc_en,
    input  logic              rx_fifo_clr,
    input  logic              tx_fifo_clr,
    input  logic              ovr_clr,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [LVL_W-1:0]  rx_level,
    output logic [LVL_W-1:0]  tx_level,
    output logic              rx_empty,
    output logic              tx_full,
    output logic              rx_irq,
    output logic              overrun,
    input  logic              core_rx_valid,
    input  logic [DATA_W-1:0] core_rx_data,
    input  logic              core_tx_ready,
    output logic              core_tx_start,
    output logic [DATA_W-1:0] core_tx_data,
    input  logic              cts,
    output logic              rts
);

    typedef struct packed {
        logic ovr;
    } top_state_t;

    top_state_t st_d, st_q;
    logic rx_full_unused, tx_empty, rx_drop, tx_drop_unused;
    logic tx_gate_open;

    ufp_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rx_fifo_clr),
        .push_i  (core_rx_valid),
        .pop_i   (rx_pop),
        .din_i   (core_rx_data),
        .dout_o  (rx_rdata),
        .level_o (rx_level),
        .full_o  (rx_full_unused),
        .empty_o (rx_empty),
        .drop_o  (rx_drop)
    );

    ufp_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tx_fifo_clr),
        .push_i  (tx_push),
        .pop_i   (core_tx_start),
        .din_i   (tx_wdata),
        .dout_o  (core_tx_data),
        .level_o (tx_level),
        .full_o  (tx_full),
        .empty_o (tx_empty),
        .drop_o  (tx_drop_unused)
    );

    ufp_rx_watch #(.DEPTH(DEPTH)) u_watch (
        .level_i    (rx_level),
        .trig_sel_i (trig_sel),
        .afc_en_i   (afc_en),
        .irq_o      (rx_irq),
        .rts_o      (rts)
    );

    always_comb begin
        tx_gate_open  = !afc_en || cts;
        core_tx_start = !tx_empty && core_tx_ready && tx_gate_open && !tx_fifo_clr;
        st_d          = st_q;
        st_d.ovr      = rx_drop || (st_q.ovr && !ovr_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overrun = st_q.ovr;

endmodule

// File: rtl/ufp_checker.sv
module ufp_checker #(
    parameter int DEPTH  = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       trig_sel,
    input logic             afc_en,
    input logic             rx_fifo_clr,
    input logic             tx_fifo_clr,
    input logic             ovr_clr,
    input logic             tx_push,
    input logic             rx_pop,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level,
    input logic             rx_irq,
    input logic             overrun,
    input logic             core_rx_valid,
    input logic             core_tx_ready,
    input logic             core_tx_start,
    input logic             cts,
    input logic             rts
);

    int unsigned trig;
    always_comb begin
        case (trig_sel)
            2'b00:   trig = 1;
            2'b01:   trig = DEPTH / 2;
            2'b10:   trig = (DEPTH * 3) / 4;
            default: trig = (DEPTH * 7) / 8;
        endcase
    end

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= LVL_W'(DEPTH)) && (tx_level <= LVL_W'(DEPTH)));

    p_irq_at_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_level) >= trig) |-> rx_irq);

    p_irq_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_level) < trig) |-> !rx_irq);

    p_rts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (afc_en && int'(rx_level) >= trig) |-> !rts);

    p_rts_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !afc_en |-> rts);

    p_cts_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (afc_en && !cts) |-> !core_tx_start);

    p_tx_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == LVL_W'(DEPTH) && tx_push && !core_tx_start && !tx_fifo_clr)
        |=> (tx_level == LVL_W'(DEPTH)));

    p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == LVL_W'(DEPTH) && core_rx_valid && !rx_pop && !rx_fifo_clr)
        |=> overrun);

    p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    p_rx_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_clr |=> (rx_level == '0));

    p_tx_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_clr |=> (tx_level == '0));

    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_start |-> (core_tx_ready && tx_level != '0));

endmodule

bind uart_fifo_path ufp_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_sel      (trig_sel),
    .afc_en        (afc_en),
    .rx_fifo_clr   (rx_fifo_clr),
    .tx_fifo_clr   (tx_fifo_clr),
    .ovr_clr       (ovr_clr),
    .tx_push       (tx_push),
    .rx_pop        (rx_pop),
    .rx_level      (rx_level),
    .tx_level      (tx_level),
    .rx_irq        (rx_irq),
    .overrun       (overrun),
    .core_rx_valid (core_rx_valid),
    .core_tx_ready (core_tx_ready),
    .core_tx_start (core_tx_start),
    .cts           (cts),
    .rts           (rts)
);

// File: tb/uart_fifo_path_bench.sv
module uart_fifo_path_bench;

    localparam int DW    = 8;
    localparam int DEPTH = 32;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic afc_en = 1'b0, rx_fifo_clr = 1'b0, tx_fifo_clr = 1'b0, ovr_clr = 1'b0;
    logic tx_push = 1'b0, rx_pop = 1'b0;
    logic [DW-1:0] tx_wdata = '0;
    logic [DW-1:0] rx_rdata;
    logic [LW-1:0] rx_level, tx_level;
    logic rx_empty, tx_full, rx_irq, overrun;
    logic core_rx_valid = 1'b0;
    logic [DW-1:0] core_rx_data = '0;
    logic core_tx_ready = 1'b0;
    logic core_tx_start;
    logic [DW-1:0] core_tx_data;
    logic cts = 1'b0;
    logic rts;

    always #10 clk = ~clk;

    uart_fifo_path #(.DATA_W(DW), .DEPTH(DEPTH)) u_uart_fifo_path (
        .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .afc_en(afc_en),
        .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr), .ovr_clr(ovr_clr),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_level(rx_level), .tx_level(tx_level), .rx_empty(rx_empty), .tx_full(tx_full),
        .rx_irq(rx_irq), .overrun(overrun), .core_rx_valid(core_rx_valid),
        .core_rx_data(core_rx_data), .core_tx_ready(core_tx_ready),
        .core_tx_start(core_tx_start), .core_tx_data(core_tx_data), .cts(cts), .rts(rts)
    );

    int n_chk = 0;
    int n_fail = 0;
    int exp_rx = 0;
    int exp_tx = 0;
    logic [DW-1:0] rxq[$];
    logic [DW-1:0] txq[$];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: one received byte from the core; expected item queued when it fits.
    task automatic rx_in(logic [DW-1:0] b);
        core_rx_valid = 1'b1;
        core_rx_data  = b;
        if (exp_rx < DEPTH) begin
            rxq.push_back(b);
            exp_rx++;
        end
        @(negedge clk);
        core_rx_valid = 1'b0;
    endtask

    // Host pop: compare the head byte with the scoreboard, then pop.
    task automatic rx_take();
        chk("R9 rx order", int'(rx_rdata), int'(rxq[0]));
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        void'(rxq.pop_front());
        exp_rx--;
        chk("R3 rx level after pop", int'(rx_level), exp_rx);
    endtask

    // Driver: host write; expected item queued when the queue has room.
    task automatic tx_in(logic [DW-1:0] b);
        tx_push  = 1'b1;
        tx_wdata = b;
        if (int'(tx_level) < DEPTH) txq.push_back(b);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pulse_rx_clr();
        rx_fifo_clr = 1'b1;
        @(negedge clk);
        rx_fifo_clr = 1'b0;
    endtask

    // Monitor: every transmit handoff pops and compares the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (core_tx_start) begin
                if (txq.size() == 0) begin
                    chk("R10 unexpected tx start", 1, 0);
                end else begin
                    chk("R9 tx order", int'(core_tx_data), int'(txq[0]));
                    void'(txq.pop_front());
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        chk("R10 watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rx_level reset", int'(rx_level), 0);
        chk("R1 tx_level reset", int'(tx_level), 0);
        chk("R1 rx_empty reset", int'(rx_empty), 1);
        chk("R1 tx_full reset", int'(tx_full), 0);
        chk("R1 rx_irq reset", int'(rx_irq), 0);
        chk("R1 overrun reset", int'(overrun), 0);

        // Trigger 1 byte, flow control on
        afc_en = 1'b1;
        trig_sel = 2'b00;
        #1;
        chk("R4 rts idle", int'(rts), 1);
        rx_in(8'hA1);
        chk("R2 irq at 1 byte", int'(rx_irq), 1);
        chk("R4 rts dropped at trigger", int'(rts), 0);
        rx_take();
        chk("R3 irq cleared", int'(rx_irq), 0);
        chk("R4 rts restored", int'(rts), 1);

        // Trigger half depth
        trig_sel = 2'b01;
        for (int i = 0; i < 15; i++) rx_in(8'(8'h10 + i));
        chk("R2 below half", int'(rx_irq), 0);
        rx_in(8'h3F);
        chk("R2 irq at half", int'(rx_irq), 1);
        chk("R4 rts at half", int'(rts), 0);
        rx_take();
        chk("R3 irq below half", int'(rx_irq), 0);
        while (exp_rx > 0) rx_take();
        chk("R1 rx empty after drain", int'(rx_empty), 1);

        // Three-quarter and seven-eighth triggers, overrun
        trig_sel = 2'b10;
        for (int i = 0; i < 23; i++) rx_in(8'(8'h40 + i));
        chk("R2 below 3/4", int'(rx_irq), 0);
        rx_in(8'h5F);
        chk("R2 irq at 3/4", int'(rx_irq), 1);
        trig_sel = 2'b11;
        #1;
        chk("R3 irq drops on higher trigger", int'(rx_irq), 0);
        for (int i = 0; i < 4; i++) rx_in(8'(8'h60 + i));
        chk("R2 irq at 7/8", int'(rx_irq), 1);
        for (int i = 0; i < 4; i++) rx_in(8'(8'h70 + i));
        chk("R1 rx full level", int'(rx_level), DEPTH);
        chk("R7 no overrun yet", int'(overrun), 0);
        rx_in(8'hEE);
        chk("R7 overrun set", int'(overrun), 1);
        chk("R7 level held", int'(rx_level), DEPTH);
        afc_en = 1'b0;
        #1;
        chk("R4 rts high without afc", int'(rts), 1);
        afc_en = 1'b1;
        #1;
        chk("R4 rts low with afc", int'(rts), 0);
        rx_take();
        chk("R7 overrun sticky", int'(overrun), 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R7 overrun cleared", int'(overrun), 0);
        rx_take();
        pulse_rx_clr();
        rxq.delete();
        exp_rx = 0;
        chk("R8 rx cleared", int'(rx_level), 0);
        chk("R8 rx_empty after clear", int'(rx_empty), 1);

        // Transmit: fill, overflow drop, CTS gate
        for (int i = 0; i < DEPTH; i++) tx_in(8'(8'h80 + i));
        chk("R1 tx full", int'(tx_full), 1);
        tx_in(8'hFF);
        chk("R6 tx level held", int'(tx_level), DEPTH);
        afc_en = 1'b1;
        cts = 1'b0;
        core_tx_ready = 1'b1;
        #1;
        chk("R5 no start with cts low", int'(core_tx_start), 0);
        repeat (3) @(negedge clk);
        chk("R5 tx level frozen", int'(tx_level), DEPTH);
        cts = 1'b1;
        for (int i = 0; i < DEPTH + 4 && tx_level != 0; i++) @(negedge clk);
        #2;
        chk("R10 tx drained", int'(tx_level), 0);
        chk("R6 dropped byte never sent", txq.size(), 0);

        // CTS ignored with flow control off
        afc_en = 1'b0;
        cts = 1'b0;
        tx_in(8'h11);
        tx_in(8'h22);
        repeat (3) @(negedge clk);
        chk("R5 cts ignored", int'(tx_level), 0);
        chk("R5 all sent", txq.size(), 0);

        // Transmit clear leaves receive queue alone
        core_tx_ready = 1'b0;
        tx_in(8'h33);
        tx_in(8'h44);
        tx_in(8'h55);
        rx_in(8'h66);
        tx_fifo_clr = 1'b1;
        @(negedge clk);
        tx_fifo_clr = 1'b0;
        txq.delete();
        chk("R8 tx cleared", int'(tx_level), 0);
        chk("R8 rx untouched", int'(rx_level), 1);
        rx_take();

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule